// File: doc/BRIEF.md
# Sixteen-Bit Capture Timer

This block is a 16-bit general-purpose timer. It counts up or down and has a small register interface for software. It picks its count rate from four clock-source enables: source 0 is always active, and the other three are strobe inputs in the same clock domain. Each selected source passes through a two-stage synchronizer, which can be bypassed, and then through a prescaler. The counter runs in one of two modes. In free-running mode it wraps at its end value. In periodic mode it reloads from a programmable load value. Every timeout sets a sticky interrupt flag, and an enable bit gates that flag onto the interrupt pin.

One of 32 event inputs can be selected. When the selected event fires, the block can copy the running count into a capture register. It can also clear both the counter and the prescaler. In match mode, a PWM output goes high when the count reaches a programmed match value and goes low at the next timeout. A load write that lands on a timeout cycle is held back for one cycle. The count readback lags the counter by the synchronizer depth unless the bypass is set.

Top module: `gpt_timer`

## Requirements
- R1: After reset, LOAD (0x00) reads 0x0000, COUNT (0x04) reads 0x0000, CTRL (0x08) reads 0x000A, and irq_o and pwm_o are low.
- R2: When CTRL bit 0 (run) is 0, the counter holds the LOAD value.
- R3: CTRL bit 1 selects the direction: 1 counts up and 0 counts down. Each prescaled step moves the count by one. A down count at 0 times out and goes to 0xFFFF. An up count at 0xFFFF times out and goes to 0. Both of these apply in free-running mode (CTRL bit 3 = 0).
- R4: With CTRL bit 3 = 1 (periodic), each timeout reloads the counter from LOAD.
- R5: The prescaler issues one step for every 4 ticks of the selected source. With CTRL bit 15 (bypass) set, it issues one step for every tick.
- R6: CTRL[6:5] selects the source. Value 0 ticks every cycle. Values 1 to 3 tick when clk_src_i[n] is high. Without bypass, the tick arrives two cycles after the strobe.
- R7: Without bypass, COUNT reads the counter value from two cycles earlier. With bypass, COUNT reads the live value.
- R8: A LOAD write in the same cycle as a timeout does not change LOAD in that cycle. The written value is applied in the following cycle, and the reload on that timeout uses the old value.
- R9: With CTRL bit 13 set, the event input chosen by CTRL[12:8] copies the count into CAPTURE (0x10). Events that are not selected have no effect.
- R10: With CTRL bit 14 set, the selected event clears the counter and the prescaler to 0.
- R11: A timeout sets a sticky flag. Writing 1 to bit 0 of CLEAR (0x0C) clears the flag, but a timeout in the same cycle takes priority. irq_o equals the flag ANDed with INTEN (0x14) bit 0. INTEN bits 15:1 read 0.
- R12: With periodic mode and CTRL bit 7 both set, a clear write also reloads the counter from LOAD.
- R13: With CTRL bit 4 set, pwm_o rises after a step in which the count equals MATCH (0x18) and falls on timeout. A match that coincides with a timeout leaves pwm_o low. With CTRL bit 4 clear, pwm_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for addr_i (combinational) |
| clk_src_i | input | 4 | Clock-source tick enables (bit 0 unused) |
| event_i | input | 32 | Event inputs |
| irq_o | output | 1 | Timeout interrupt |
| pwm_o | output | 1 | Match-mode PWM output |

## Verification
The bench writes LOAD on every cycle across several periodic timeouts. A design that does not defer the write would either reload from the new value or lose the write altogether. It reads COUNT in both synchronized and bypassed modes. Returning the live value, or a value delayed by the wrong number of cycles, shows up as a mismatch on the first step after the counter is enabled. It sets MATCH equal to the timeout value. A design that lets a match win over a coincident timeout raises pwm_o when it should stay low. It also pulses selected and unselected events, so a wrong event index or a counter reset that leaves the prescaler running changes the capture value or the next-step timing.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam logic [4:0] A_LOAD  = 5'h00;
  localparam logic [4:0] A_COUNT = 5'h04;
  localparam logic [4:0] A_CTRL  = 5'h08;
  localparam logic [4:0] A_CLR   = 5'h0C;
  localparam logic [4:0] A_CAPT  = 5'h10;
  localparam logic [4:0] A_IEN   = 5'h14;
  localparam logic [4:0] A_MATCH = 5'h18;

  typedef struct packed {
    logic       byp;
    logic       erst;
    logic       capen;
    logic [4:0] esel;
    logic       rld;
    logic [1:0] csel;
    logic       pwm;
    logic       per;
    logic       rsvd;
    logic       up;
    logic       run;
  } ctrl_t;

  localparam logic [15:0] CTRL_RST = 16'h000A;
endpackage

// File: rtl/gpt_tick.sv
module gpt_tick #(
  parameter int N_SRC   = 4,
  parameter int SYNC_N  = 2,
  parameter int PRE_W   = 8,
  parameter int PRE_MAX = 3,
  localparam int SEL_W  = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             bypass_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic             step_o,
  output logic [PRE_W-1:0] pre_o
);
  logic             raw, tick;
  logic [SYNC_N-1:0] sync_q;
  logic [PRE_W-1:0] pre_q, pre_max;

  assign raw = (sel_i == '0) ? 1'b1 : src_i[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], raw};

  assign tick    = bypass_i ? raw : sync_q[SYNC_N-1];
  assign pre_max = bypass_i ? '0 : PRE_W'(PRE_MAX);
  assign step_o  = run_i & tick & (pre_q >= pre_max) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (run_i && tick)  pre_q <= (pre_q >= pre_max) ? '0 : pre_q + 1'b1;

  assign pre_o = pre_q;
endmodule

// File: rtl/gpt_count.sv
module gpt_count #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             up_i,
  input  logic             periodic_i,
  input  logic             step_i,
  input  logic             evt_rst_i,
  input  logic             clr_reload_i,
  input  logic             cap_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             bypass_i,
  output logic             timeout_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] cnt_rd_o
);
  logic [CNT_W-1:0] cnt_q, load_q, pend_val_q, cap_q;
  logic             pend_q;
  logic [CNT_W-1:0] dly_q [SYNC_N];

  assign timeout_o = step_i & (up_i ? (cnt_q == '1) : (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= load_q;
    else if (evt_rst_i)      cnt_q <= '0;
    else if (timeout_o)      cnt_q <= periodic_i ? load_q : (up_i ? '0 : '1);
    else if (step_i)         cnt_q <= up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
    else if (clr_reload_i)   cnt_q <= load_q;

  // load writes landing on a timeout wait one cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      load_q <= '0; pend_q <= 1'b0; pend_val_q <= '0;
    end else if (load_wr_i && timeout_o) begin
      pend_q <= 1'b1; pend_val_q <= wdata_i;
    end else if (load_wr_i) begin
      load_q <= wdata_i; pend_q <= 1'b0;
    end else if (pend_q) begin
      load_q <= pend_val_q; pend_q <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cap_q <= '0;
    else if (cap_i) cap_q <= cnt_q;

  for (genvar i = 0; i < SYNC_N; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) dly_q[i] <= '0;
      else         dly_q[i] <= (i == 0) ? cnt_q : dly_q[(i == 0) ? 0 : i-1];
  end

  assign cnt_o    = cnt_q;
  assign load_o   = load_q;
  assign cap_o    = cap_q;
  assign cnt_rd_o = bypass_i ? cnt_q : dly_q[SYNC_N-1];
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int N_SRC   = 4,
  parameter int N_EVT   = 32,
  parameter int SYNC_N  = 2,
  parameter int PRE_W   = 8,
  parameter int PRE_MAX = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [N_SRC-1:0]  clk_src_i,
  input  logic [N_EVT-1:0]  event_i,
  output logic              irq_o,
  output logic              pwm_o
);
  localparam int CNT_W = DATA_W;

  ctrl_t            ctl_q;
  logic             ie_q, flag_q, pwm_q;
  logic [CNT_W-1:0] match_q, cnt, load, cap, cnt_rd;
  logic [PRE_W-1:0] pre;
  logic             step, timeout, evt, evt_rst, cap_hit, clr_hit;
  logic             wr_load, wr_ctl, wr_clr, wr_ien, wr_match;

  assign wr_load  = wr_en_i && (addr_i == A_LOAD);
  assign wr_ctl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_clr   = wr_en_i && (addr_i == A_CLR);
  assign wr_ien   = wr_en_i && (addr_i == A_IEN);
  assign wr_match = wr_en_i && (addr_i == A_MATCH);
  assign clr_hit  = wr_clr & wdata_i[0];

  assign evt     = event_i[ctl_q.esel];
  assign evt_rst = evt & ctl_q.erst;
  assign cap_hit = evt & ctl_q.capen;

  gpt_tick #(.N_SRC(N_SRC), .SYNC_N(SYNC_N), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_tick (
    .clk_i, .rst_ni,
    .src_i    (clk_src_i),
    .sel_i    (ctl_q.csel),
    .bypass_i (ctl_q.byp),
    .run_i    (ctl_q.run),
    .clr_i    (evt_rst),
    .step_o   (step),
    .pre_o    (pre)
  );

  gpt_count #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt (
    .clk_i, .rst_ni,
    .run_i        (ctl_q.run),
    .up_i         (ctl_q.up),
    .periodic_i   (ctl_q.per),
    .step_i       (step),
    .evt_rst_i    (evt_rst),
    .clr_reload_i (clr_hit & ctl_q.per & ctl_q.rld),
    .cap_i        (cap_hit),
    .load_wr_i    (wr_load),
    .wdata_i      (wdata_i),
    .bypass_i     (ctl_q.byp),
    .timeout_o    (timeout),
    .cnt_o        (cnt),
    .load_o       (load),
    .cap_o        (cap),
    .cnt_rd_o     (cnt_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctl_q <= CTRL_RST; ie_q <= 1'b0; match_q <= '0;
    end else begin
      if (wr_ctl)   ctl_q   <= ctrl_t'(wdata_i);
      if (wr_ien)   ie_q    <= wdata_i[0];
      if (wr_match) match_q <= wdata_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       flag_q <= 1'b0;
    else if (timeout)  flag_q <= 1'b1;
    else if (clr_hit)  flag_q <= 1'b0;

  // timeout wins over a coincident match
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     pwm_q <= 1'b0;
    else if (!ctl_q.pwm || timeout)  pwm_q <= 1'b0;
    else if (step && cnt == match_q) pwm_q <= 1'b1;

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_LOAD:  rd_data_o = load;
      A_COUNT: rd_data_o = cnt_rd;
      A_CTRL:  rd_data_o = ctl_q;
      A_CAPT:  rd_data_o = cap;
      A_IEN:   rd_data_o = {{(DATA_W-1){1'b0}}, ie_q};
      A_MATCH: rd_data_o = match_q;
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = flag_q & ie_q;
  assign pwm_o = pwm_q;
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
  import gpt_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input ctrl_t       ctl_q,
  input logic        step,
  input logic        timeout,
  input logic        evt_rst,
  input logic [15:0] cnt,
  input logic [15:0] load,
  input logic [7:0]  pre,
  input logic        flag_q,
  input logic        pwm_o,
  input logic [4:0]  addr_i,
  input logic [15:0] rd_data_o
);
  assert_down_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !timeout && !evt_rst && !ctl_q.up |=> cnt == $past(cnt) - 16'd1);

  assert_periodic_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout && ctl_q.per && !evt_rst |=> cnt == $past(load));

  assert_load_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> load == $past(load));

  assert_evt_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_rst && ctl_q.run |=> cnt == 16'd0 && pre == 8'd0);

  assert_flag_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> flag_q);

  assert_ien_rsvd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_IEN |-> rd_data_o[15:1] == 15'd0);

  assert_pwm_drop_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> !pwm_o);
endmodule

bind gpt_timer gpt_timer_chk u_chk (.*);

// File: tb/gpt_timer_tb.sv
module gpt_timer_tb;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  addr = 0;
  logic        we = 0;
  logic [15:0] wd = 0;
  logic [15:0] rd;
  logic [3:0]  src = 0;
  logic [31:0] ev = 0;
  logic        irq, pwm;

  int checks = 0, fails = 0;
  bit cmp_on = 0, done = 0;
  string phase = "R1";

  gpt_timer u_dut (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wd),
    .rd_data_o(rd), .clk_src_i(src), .event_i(ev), .irq_o(irq), .pwm_o(pwm));

  always #10 clk = ~clk;

  // behavioural reference
  int m_cnt = 0, m_load = 0, m_pend = 0, m_pval = 0, m_cap = 0, m_flag = 0, m_pwm = 0;
  int m_r1 = 0, m_r2 = 0, m_s1 = 0, m_s2 = 0, m_pre = 0, m_ctl = 'hA, m_ie = 0, m_match = 0;
  int en, up, per, pm, rld, cs, es, capen, rsten, byp, raw, tk, pmax, evt, erst, step, to;
  int wl, wclr, n_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_pend = 0; m_pval = 0; m_cap = 0; m_flag = 0; m_pwm = 0;
      m_r1 = 0; m_r2 = 0; m_s1 = 0; m_s2 = 0; m_pre = 0; m_ctl = 'hA; m_ie = 0; m_match = 0;
    end else begin
      en = m_ctl & 1; up = (m_ctl >> 1) & 1; per = (m_ctl >> 3) & 1; pm = (m_ctl >> 4) & 1;
      cs = (m_ctl >> 5) & 3; rld = (m_ctl >> 7) & 1; es = (m_ctl >> 8) & 31;
      capen = (m_ctl >> 13) & 1; rsten = (m_ctl >> 14) & 1; byp = (m_ctl >> 15) & 1;
      raw = (cs == 0) ? 1 : int'(src[cs]);
      tk = byp ? raw : m_s2;
      pmax = byp ? 0 : 3;
      evt = int'(ev[es]); erst = evt & rsten;
      step = (en && tk && m_pre >= pmax && !erst) ? 1 : 0;
      to = (step && (up ? m_cnt == 'hFFFF : m_cnt == 0)) ? 1 : 0;
      wl = (we && addr == 5'h00) ? 1 : 0;
      wclr = (we && addr == 5'h0C && wd[0]) ? 1 : 0;
      if (!en) n_cnt = m_load;
      else if (erst) n_cnt = 0;
      else if (to) n_cnt = per ? m_load : (up ? 0 : 'hFFFF);
      else if (step) n_cnt = up ? (m_cnt + 1) & 'hFFFF : (m_cnt - 1) & 'hFFFF;
      else if (wclr && per && rld) n_cnt = m_load;
      else n_cnt = m_cnt;
      if (evt && capen) m_cap = m_cnt;
      if (!pm || to) m_pwm = 0;
      else if (step && m_cnt == m_match) m_pwm = 1;
      if (to) m_flag = 1; else if (wclr) m_flag = 0;
      if (wl && to) begin m_pend = 1; m_pval = wd; end
      else if (wl) begin m_load = wd; m_pend = 0; end
      else if (m_pend) begin m_load = m_pval; m_pend = 0; end
      if (erst) m_pre = 0;
      else if (en && tk) m_pre = (m_pre >= pmax) ? 0 : m_pre + 1;
      m_s2 = m_s1; m_s1 = raw;
      m_r2 = m_r1; m_r1 = m_cnt;
      m_cnt = n_cnt;
      if (we && addr == 5'h08) m_ctl = wd;
      if (we && addr == 5'h14) m_ie = wd[0];
      if (we && addr == 5'h18) m_match = wd;
    end
  end

  function automatic int m_rd(input logic [4:0] a);
    case (a)
      5'h00: return m_load;
      5'h04: return ((m_ctl >> 15) & 1) ? m_cnt : m_r2;
      5'h08: return m_ctl;
      5'h10: return m_cap;
      5'h14: return m_ie;
      5'h18: return m_match;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    #2;
    chk({rd, 6'd0, irq, pwm}, (m_rd(addr) << 8) | ((m_flag & m_ie) << 1) | m_pwm, phase);
  end

  task automatic wr(input logic [4:0] a, input int d);
    logic [4:0] keep;
    @(negedge clk); keep = addr; addr = a; we = 1; wd = d[15:0];
    @(negedge clk); we = 0; addr = keep;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(input logic [4:0] a);
    @(negedge clk); addr = a;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); ev[i] = 1;
    @(negedge clk); ev[i] = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  bit seen;
  initial begin
    idle(2); rst_n = 1;
    // R1 reset values
    look(5'h00); #2 chk(rd, 0, "R1 LOAD");
    look(5'h04); #2 chk(rd, 0, "R1 COUNT");
    look(5'h08); #2 chk(rd, 'h000A, "R1 CTRL");
    chk({irq, pwm}, 0, "R1 outputs");
    cmp_on = 1;

    // R2 stopped counter follows LOAD
    phase = "R2";
    wr(5'h08, 'h0000); wr(5'h00, 'h1234); look(5'h04); idle(3);
    #2 chk(rd, 'h1234, "R2 COUNT");

    // R3 R5 R6 R7: free-running down, synchronized, prescaled
    phase = "R3 R5 R6 R7 down sync";
    wr(5'h14, 'h0001); wr(5'h00, 5); wr(5'h08, 'h0001); look(5'h04); idle(40);
    #2 chk(irq, 1, "R11 irq after timeout");
    phase = "R11 clear";
    wr(5'h0C, 1); #2 chk(irq, 0, "R11 irq cleared");
    look(5'h14); wr(5'h14, 'hFFFF); #2 chk(rd, 1, "R11 INTEN reserved bits");

    // R3 R4 R7: periodic up, bypass
    phase = "R3 R4 R7 up periodic bypass";
    wr(5'h08, 'h0000); wr(5'h00, 'hFFFC); wr(5'h08, 'h800B); look(5'h04); idle(20);

    // R8: LOAD writes every cycle across timeouts
    phase = "R8 deferred load";
    wr(5'h08, 'h0000); wr(5'h00, 2); wr(5'h08, 'h8009);
    for (int i = 0; i < 24; i++) wr(5'h00, 2 + (i % 3));
    look(5'h00); idle(4);

    // R6 R12: source 1 strobes, then clear-with-reload
    phase = "R6 R12";
    wr(5'h08, 'h0000); wr(5'h00, 'h20); wr(5'h08, 'h80A9); look(5'h04);
    src[1] = 1; idle(5); src[1] = 0; idle(2);
    wr(5'h0C, 1); #2 chk(rd, 'h20, "R12 reload on clear");
    phase = "R6 sync source";
    wr(5'h08, 'h00A1);
    for (int i = 0; i < 30; i++) begin @(negedge clk); src[2] = i[0]; src[1] = i[1]; end
    wr(5'h08, 'h00C1); idle(20); src = 0;

    // R9 capture
    phase = "R9";
    wr(5'h08, 'h0000); wr(5'h00, 'h0077); wr(5'h08, 'h2700); pulse(7);
    look(5'h10); #2 chk(rd, 'h0077, "R9 capture selected");
    wr(5'h00, 'h0055); pulse(3); idle(2); #2 chk(rd, 'h0077, "R9 unselected ignored");

    // R10 event reset
    phase = "R10";
    wr(5'h00, 'h0100); wr(5'h08, 'hC503); look(5'h04); idle(6);
    @(negedge clk); ev[5] = 1; @(negedge clk); ev[5] = 0;
    #2 chk(rd, 0, "R10 counter cleared");
    wr(5'h08, 'h4503); idle(4); pulse(5); idle(12);

    // R13 PWM
    phase = "R13 match";
    wr(5'h08, 'h0000); wr(5'h00, 6); wr(5'h18, 3); wr(5'h08, 'h8019); look(5'h18);
    seen = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); #2 if (pwm) seen = 1; end
    chk(seen, 1, "R13 pwm asserted on match");
    phase = "R13 coincident";
    wr(5'h18, 0); idle(8);
    seen = 0;
    for (int i = 0; i < 24; i++) begin @(negedge clk); #2 if (pwm) seen = 1; end
    chk(seen, 0, "R13 pwm idle when match hits timeout");
    wr(5'h08, 'h8009); idle(4); #2 chk(pwm, 0, "R13 mode off");

    cmp_on = 0;
    finish_up();
  end
endmodule